// File: doc/BRIEF.md
# Object Descriptor Address Translator

This unit turns a capability-style memory operand into either a physical address or a request for a page-table walk. The operand consists of two parts. The first is a 32-bit access descriptor, which carries permission bits and an object index. The second is an effective offset, formed by summing a base offset, an instruction displacement and an optional index value. The object index selects an entry in a local table of object descriptors. Each entry holds an object type, a length in bytes and a physical pointer.

The object type decides what the pointer means and what is produced:
- For a direct object, the pointer is the base of the data, and the physical address is the pointer plus the offset.
- For a one-level paged object, the pointer addresses a single page table. The unit emits the pointer together with the page number and the byte-in-page fields of the offset.
- For a two-level paged object, the pointer addresses the top-level table. The page number is also split into a top index and a second-level index.

The unit does not read page tables. A walker downstream consumes the request fields.

Faults are detected in a fixed priority: an absent object, then a missing permission, then a reserved type, then an out-of-range offset. Every request yields exactly one response, one clock later. The descriptor table is loaded through a simple write port.

Top module: `obj_xlat`

## Requirements
- R1: The effective offset is the 32-bit wrapping sum baseOff + disp + idxVal. idxVal is added only when idxEn is 1; otherwise it has no effect on any output.
- R2: accDesc[25:0] is the object index, accDesc[26] grants read and accDesc[27] grants write. accDesc[31:28] have no effect on any output.
- R3: When tblWe is 1 at a clock edge, table entry tblSel is written with tblKind, tblLen and tblPtr. A request reads the entry selected by the low 6 bits of the object index, and a rewritten entry governs all later requests.
- R4: An object index of 64 or more gives rspFault = 1 (no such object), whatever the permissions and offset.
- R5: A load (reqStore = 0) without read permission, or a store (reqStore = 1) without write permission, gives rspFault = 2. This fault takes priority over the type and bounds faults.
- R6: Type code 3 is reserved and gives rspFault = 3. This fault takes priority over the bounds fault.
- R7: An effective offset greater than or equal to the entry length gives rspFault = 4. An offset of length-1 is accepted.
- R8: For a type 0 (direct) object, a successful response has rspKind = 0 and rspAddr = pointer + offset (32-bit wrap). rspPageNum, rspPageOff, rspTopIdx and rspSecIdx are all 0.
- R9: For a type 1 (one-level paged) object, a successful response has rspKind = 1, rspAddr = pointer, rspPageNum = offset[31:12] and rspPageOff = offset[11:0]. rspTopIdx and rspSecIdx are 0.
- R10: For a type 2 (two-level paged) object, a successful response has rspKind = 2, rspAddr = pointer, rspPageNum = offset[31:12], rspTopIdx = offset[31:22], rspSecIdx = offset[21:12] and rspPageOff = offset[11:0].
- R11: rspValid is high for exactly the one cycle following each cycle in which reqValid is high. rspFault is 0 on success. On any fault, rspKind, rspAddr and all page fields are 0.
- R12: After reset, rspValid and all response outputs are 0, and every table entry is type 0 with length 0 and pointer 0. As a result, any permitted request to an existing object raises the bounds fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tblWe | input | 1 | Descriptor table write enable |
| tblSel | input | 6 | Table entry to write |
| tblKind | input | 2 | Object type to write |
| tblLen | input | 32 | Object length to write |
| tblPtr | input | 32 | Object pointer to write |
| reqValid | input | 1 | Translation request strobe |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| accDesc | input | 32 | Access descriptor |
| baseOff | input | 32 | Base offset |
| disp | input | 32 | Instruction displacement |
| idxVal | input | 32 | Index register value |
| idxEn | input | 1 | Include idxVal in the offset |
| rspValid | output | 1 | Response strobe |
| rspFault | output | 3 | Fault code, 0 on success |
| rspKind | output | 2 | Response type (direct, one-level, two-level) |
| rspAddr | output | 32 | Physical address or table pointer |
| rspPageNum | output | 20 | Page number from the offset |
| rspPageOff | output | 12 | Byte offset within the page |
| rspTopIdx | output | 10 | Top-level table index |
| rspSecIdx | output | 10 | Second-level table index |

## Verification
The bench first loads all 64 entries, cycling through the four type codes. It then sweeps every permission pair, both access directions and offsets at 0, length-1, length and beyond. Each offset is built both with and without the index term.

The sweep targets specific failure modes:
- An off-by-one in the bounds compare would either reject length-1 or accept length.
- A wrong fault priority would report a bounds or type fault where a missing permission must win.
- A design that ignored idxEn, or decoded the spare descriptor bits, would produce a wrong address when the bench sets those inputs to junk.

Object indices at 64, at the top of the 26-bit range, and with an in-table low part but a high bit set, catch a table lookup that aliases instead of faulting. Requests made straight after reset catch a table that does not clear to length 0.

// File: rtl/objx_pkg.sv
package objx_pkg;

  typedef enum logic [1:0] {
    OBJ_DIRECT = 2'd0,
    OBJ_PAGED1 = 2'd1,
    OBJ_PAGED2 = 2'd2,
    OBJ_RSVD   = 2'd3
  } objKind_e;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_OBJ   = 3'd1,
    FLT_PERM  = 3'd2,
    FLT_TYPE  = 3'd3,
    FLT_BOUND = 3'd4
  } fault_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   load;
    logic   fault;
    fault_e code;
  } ctrlStrobe_t;

endpackage

// File: rtl/objx_ctrl.sv
module objx_ctrl
  import objx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqStore,
  input  logic        permRd,
  input  logic        permWr,
  input  logic        objInRange,
  input  objKind_e    entKind,
  input  logic        offInBounds,
  output ctrlStrobe_t strobe
);

  logic permOk;
  assign permOk = reqStore ? permWr : permRd;

  always_comb begin
    strobe.load  = reqValid;
    strobe.fault = 1'b1;
    if (!objInRange)             strobe.code = FLT_OBJ;
    else if (!permOk)            strobe.code = FLT_PERM;
    else if (entKind == OBJ_RSVD) strobe.code = FLT_TYPE;
    else if (!offInBounds)       strobe.code = FLT_BOUND;
    else begin
      strobe.code  = FLT_NONE;
      strobe.fault = 1'b0;
    end
  end

  // R5
  store_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.fault && reqStore) |-> permWr);

  // R5
  load_needs_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.fault && !reqStore) |-> permRd);

  // R7
  success_in_bounds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && !strobe.fault) |-> (offInBounds && objInRange));

endmodule

// File: rtl/objx_datapath.sv
module objx_datapath
  import objx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 26,
  parameter int TBL_DEPTH = 64,
  parameter int PAGE_BITS = 12,
  parameter int LVL_BITS  = 10,
  localparam int TBL_AW   = $clog2(TBL_DEPTH),
  localparam int VPN_W    = ADDR_W - PAGE_BITS
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tblWe,
  input  logic [TBL_AW-1:0] tblSel,
  input  logic [1:0]        tblKind,
  input  logic [ADDR_W-1:0] tblLen,
  input  logic [ADDR_W-1:0] tblPtr,
  input  logic [IDX_W-1:0]  objIndex,
  input  logic [ADDR_W-1:0] baseOff,
  input  logic [ADDR_W-1:0] disp,
  input  logic [ADDR_W-1:0] idxVal,
  input  logic              idxEn,
  input  ctrlStrobe_t       strobe,
  output logic              objInRange,
  output objKind_e          entKind,
  output logic              offInBounds,
  output logic              rspValid,
  output logic [2:0]        rspFault,
  output logic [1:0]        rspKind,
  output logic [ADDR_W-1:0] rspAddr,
  output logic [VPN_W-1:0]  rspPageNum,
  output logic [PAGE_BITS-1:0] rspPageOff,
  output logic [LVL_BITS-1:0]  rspTopIdx,
  output logic [LVL_BITS-1:0]  rspSecIdx
);

  objKind_e          kindMem [TBL_DEPTH];
  logic [ADDR_W-1:0] lenMem  [TBL_DEPTH];
  logic [ADDR_W-1:0] ptrMem  [TBL_DEPTH];

  logic [TBL_AW-1:0] sel;
  logic [ADDR_W-1:0] effOff;
  logic [ADDR_W-1:0] entPtr;
  logic [VPN_W-1:0]  vpn;

  assign sel         = objIndex[TBL_AW-1:0];
  assign objInRange  = (objIndex < IDX_W'(TBL_DEPTH));
  assign effOff      = baseOff + disp + (idxEn ? idxVal : '0);
  assign entKind     = kindMem[sel];
  assign entPtr      = ptrMem[sel];
  assign offInBounds = (effOff < lenMem[sel]);
  assign vpn         = effOff[ADDR_W-1:PAGE_BITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < TBL_DEPTH; i++) begin
        kindMem[i] <= OBJ_DIRECT;
        lenMem[i]  <= '0;
        ptrMem[i]  <= '0;
      end
    end else if (tblWe) begin
      kindMem[tblSel] <= objKind_e'(tblKind);
      lenMem[tblSel]  <= tblLen;
      ptrMem[tblSel]  <= tblPtr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid   <= 1'b0;
      rspFault   <= '0;
      rspKind    <= '0;
      rspAddr    <= '0;
      rspPageNum <= '0;
      rspPageOff <= '0;
      rspTopIdx  <= '0;
      rspSecIdx  <= '0;
    end else begin
      rspValid <= strobe.load;
      if (strobe.load) begin
        rspFault   <= strobe.code;
        rspKind    <= '0;
        rspAddr    <= '0;
        rspPageNum <= '0;
        rspPageOff <= '0;
        rspTopIdx  <= '0;
        rspSecIdx  <= '0;
        if (!strobe.fault) begin
          rspKind <= entKind;
          unique case (entKind)
            OBJ_DIRECT: rspAddr <= entPtr + effOff;
            OBJ_PAGED1: begin
              rspAddr    <= entPtr;
              rspPageNum <= vpn;
              rspPageOff <= effOff[PAGE_BITS-1:0];
            end
            default: begin
              rspAddr    <= entPtr;
              rspPageNum <= vpn;
              rspPageOff <= effOff[PAGE_BITS-1:0];
              rspTopIdx  <= vpn[VPN_W-1 -: LVL_BITS];
              rspSecIdx  <= vpn[LVL_BITS-1:0];
            end
          endcase
        end
      end
    end
  end

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> rspValid);

  // R11
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> !rspValid);

  // R11
  fault_zeroes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 3'd0) |-> (rspAddr == '0 && rspPageNum == '0 && rspKind == 2'd0));

  // R6
  no_rsvd_ok_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 3'd0) |-> (rspKind != 2'd3));

  // R8
  direct_no_page_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 3'd0 && rspKind == 2'd0) |-> (rspPageNum == '0 && rspPageOff == '0));

  // R10
  split_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault == 3'd0 && rspKind == 2'd2) |-> ({rspTopIdx, rspSecIdx} == rspPageNum));

endmodule

// File: rtl/obj_xlat.sv
module obj_xlat
  import objx_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 26,
  parameter int TBL_DEPTH = 64,
  parameter int PAGE_BITS = 12,
  parameter int LVL_BITS  = 10,
  localparam int TBL_AW   = $clog2(TBL_DEPTH),
  localparam int VPN_W    = ADDR_W - PAGE_BITS
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tblWe,
  input  logic [TBL_AW-1:0]    tblSel,
  input  logic [1:0]           tblKind,
  input  logic [ADDR_W-1:0]    tblLen,
  input  logic [ADDR_W-1:0]    tblPtr,
  input  logic                 reqValid,
  input  logic                 reqStore,
  input  logic [ADDR_W-1:0]    accDesc,
  input  logic [ADDR_W-1:0]    baseOff,
  input  logic [ADDR_W-1:0]    disp,
  input  logic [ADDR_W-1:0]    idxVal,
  input  logic                 idxEn,
  output logic                 rspValid,
  output logic [2:0]           rspFault,
  output logic [1:0]           rspKind,
  output logic [ADDR_W-1:0]    rspAddr,
  output logic [VPN_W-1:0]     rspPageNum,
  output logic [PAGE_BITS-1:0] rspPageOff,
  output logic [LVL_BITS-1:0]  rspTopIdx,
  output logic [LVL_BITS-1:0]  rspSecIdx
);

  ctrlStrobe_t strobe;
  objKind_e    entKind;
  logic        objInRange;
  logic        offInBounds;
  logic        unusedPermHi;

  assign unusedPermHi = ^accDesc[ADDR_W-1:IDX_W+2];

  objx_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqStore   (reqStore),
    .permRd     (accDesc[IDX_W]),
    .permWr     (accDesc[IDX_W+1]),
    .objInRange (objInRange),
    .entKind    (entKind),
    .offInBounds(offInBounds),
    .strobe     (strobe)
  );

  objx_datapath #(
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W),
    .TBL_DEPTH(TBL_DEPTH),
    .PAGE_BITS(PAGE_BITS),
    .LVL_BITS (LVL_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .tblWe      (tblWe),
    .tblSel     (tblSel),
    .tblKind    (tblKind),
    .tblLen     (tblLen),
    .tblPtr     (tblPtr),
    .objIndex   (accDesc[IDX_W-1:0]),
    .baseOff    (baseOff),
    .disp       (disp),
    .idxVal     (idxVal),
    .idxEn      (idxEn),
    .strobe     (strobe),
    .objInRange (objInRange),
    .entKind    (entKind),
    .offInBounds(offInBounds),
    .rspValid   (rspValid),
    .rspFault   (rspFault),
    .rspKind    (rspKind),
    .rspAddr    (rspAddr),
    .rspPageNum (rspPageNum),
    .rspPageOff (rspPageOff),
    .rspTopIdx  (rspTopIdx),
    .rspSecIdx  (rspSecIdx)
  );

endmodule

// File: tb/tb_obj_xlat.sv
`timescale 1ns/1ps
module tb_obj_xlat;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tblWe = 1'b0;
  logic [5:0]  tblSel = '0;
  logic [1:0]  tblKind = '0;
  logic [31:0] tblLen = '0, tblPtr = '0;
  logic        reqValid = 1'b0, reqStore = 1'b0, idxEn = 1'b0;
  logic [31:0] accDesc = '0, baseOff = '0, disp = '0, idxVal = '0;
  logic        rspValid;
  logic [2:0]  rspFault;
  logic [1:0]  rspKind;
  logic [31:0] rspAddr;
  logic [19:0] rspPageNum;
  logic [11:0] rspPageOff;
  logic [9:0]  rspTopIdx, rspSecIdx;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [1:0]  shKind [64];
  logic [31:0] shLen  [64];
  logic [31:0] shPtr  [64];

  always #4 clk = ~clk;

  obj_xlat dut (
    .clk(clk), .rstN(rstN), .tblWe(tblWe), .tblSel(tblSel), .tblKind(tblKind),
    .tblLen(tblLen), .tblPtr(tblPtr), .reqValid(reqValid), .reqStore(reqStore),
    .accDesc(accDesc), .baseOff(baseOff), .disp(disp), .idxVal(idxVal), .idxEn(idxEn),
    .rspValid(rspValid), .rspFault(rspFault), .rspKind(rspKind), .rspAddr(rspAddr),
    .rspPageNum(rspPageNum), .rspPageOff(rspPageOff), .rspTopIdx(rspTopIdx),
    .rspSecIdx(rspSecIdx)
  );

  task automatic check(input bit ok, input string rq, input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic writeEnt(input int s, input logic [1:0] k, input logic [31:0] l, input logic [31:0] p);
    @(negedge clk);
    tblWe = 1'b1; tblSel = 6'(s); tblKind = k; tblLen = l; tblPtr = p;
    @(negedge clk);
    tblWe = 1'b0;
    shKind[s] = k; shLen[s] = l; shPtr[s] = p;
  endtask

  task automatic apply(input logic st, input logic [31:0] ad, input logic [31:0] b,
                       input logic [31:0] d, input logic [31:0] ix, input logic ie,
                       input string rq);
    logic [31:0] off, eAddr;
    logic [2:0]  eF;
    logic [1:0]  eK;
    logic [19:0] eVpn;
    logic [11:0] ePo;
    logic [9:0]  eTop, eSec;
    logic [95:0] act, exp;
    int          oi;
    @(negedge clk);
    // R11: idle between requests
    check(rspValid == 1'b0, "R11", {95'd0, rspValid}, 96'd0);
    reqValid = 1'b1; reqStore = st; accDesc = ad; baseOff = b; disp = d; idxVal = ix; idxEn = ie;
    @(negedge clk);
    reqValid = 1'b0;
    off = b + d + (ie ? ix : 32'd0);
    eF = 3'd0; eK = 2'd0; eAddr = '0; eVpn = '0; ePo = '0; eTop = '0; eSec = '0;
    if (ad[25:0] >= 26'd64) eF = 3'd1;
    else begin
      oi = int'(ad[5:0]);
      if (st ? !ad[27] : !ad[26]) eF = 3'd2;
      else if (shKind[oi] == 2'd3) eF = 3'd3;
      else if (off >= shLen[oi]) eF = 3'd4;
      else begin
        eK = shKind[oi];
        if (eK == 2'd0) eAddr = shPtr[oi] + off;
        else begin
          eAddr = shPtr[oi]; eVpn = off[31:12]; ePo = off[11:0];
          if (eK == 2'd2) begin eTop = off[31:22]; eSec = off[21:12]; end
        end
      end
    end
    act = {rspValid, rspFault, rspKind, rspAddr, rspPageNum, rspPageOff, rspTopIdx, rspSecIdx};
    exp = {1'b1, eF, eK, eAddr, eVpn, ePo, eTop, eSec};
    check(act == exp, rq, act, exp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin shKind[i] = '0; shLen[i] = '0; shPtr[i] = '0; end
    repeat (3) @(negedge clk);
    // R12: reset state of outputs
    check({rspValid, rspFault, rspKind, rspAddr, rspPageNum, rspPageOff, rspTopIdx, rspSecIdx} == '0,
          "R12", {rspValid, rspFault, rspKind, rspAddr, rspPageNum, rspPageOff, rspTopIdx, rspSecIdx}, '0);
    rstN = 1'b1;
    // R12: cleared table gives bounds fault
    apply(1'b0, 32'h0400_0007, 32'd0, 32'd0, 32'd0, 1'b0, "R12");
    apply(1'b1, 32'h0C00_003F, 32'd0, 32'd0, 32'd0, 1'b0, "R12");

    for (int i = 0; i < 64; i++) begin
      logic [31:0] l;
      l = ((i % 4) == 0) ? 32'h100 + 32'(i) * 32'h10 : 32'hFFFF_F000 - 32'(i) * 32'h1000;
      writeEnt(i, 2'(i % 4), l, 32'h8000_0000 + 32'(i) * 32'h0001_0040);
    end

    foreach (shKind[j]) begin end
    for (int o = 0; o < 8; o++) begin
      int obj;
      obj = (o < 4) ? o : ((o == 4) ? 5 : (o == 5) ? 6 : (o == 6) ? 62 : 63);
      for (int p = 0; p < 4; p++)
        for (int st = 0; st < 2; st++)
          for (int k = 0; k < 5; k++) begin
            logic [31:0] tgt, ad;
            logic ie;
            case (k)
              0: tgt = 32'd0;
              1: tgt = shLen[obj] - 32'd1;
              2: tgt = shLen[obj];
              3: tgt = shLen[obj] + 32'h123;
              default: tgt = 32'h0123_4567 + 32'(obj) * 32'h0040_1001;
            endcase
            ie = ((k + p) % 2) == 1;
            // R2: junk in bits 31:28
            ad = {4'(k * 3 + st), 2'(p), 26'(obj)};
            // R1 R5 R6 R7 R8 R9 R10: sweep over type, permission, direction and offset
            apply(st[0], ad, tgt - 32'h30 - (ie ? 32'h0000_1010 : 32'd0), 32'h30,
                  ie ? 32'h0000_1010 : 32'hDEAD_BEEF, ie,
                  (shKind[obj] == 2'd0) ? "R8/R7/R5/R1" : (shKind[obj] == 2'd1) ? "R9/R7/R5/R1" :
                  (shKind[obj] == 2'd2) ? "R10/R7/R5/R1" : "R6/R5");
          end
    end

    // R4: indices outside the table, including aliasing low bits
    for (int p = 0; p < 4; p++) begin
      apply(1'b0, {4'hA, 2'(p), 26'd64}, 32'd0, 32'd0, 32'd0, 1'b0, "R4");
      apply(1'b1, {4'h0, 2'(p), 26'h3FF_FFFF}, 32'd4, 32'd0, 32'd0, 1'b0, "R4");
      apply(1'b0, {4'h5, 2'(p), 26'h200_0005}, 32'd0, 32'd0, 32'd0, 1'b0, "R4");
    end

    // R3: rewrite entry 5 and observe the new contents
    writeEnt(5, 2'd2, 32'hFFFF_FFFF, 32'h0000_2000);
    apply(1'b0, 32'h0400_0005, 32'hABCD_E000, 32'h0000_0123, 32'd0, 1'b0, "R3");
    writeEnt(5, 2'd0, 32'h0000_0010, 32'h0000_4000);
    apply(1'b1, 32'h0800_0005, 32'h0000_000F, 32'd0, 32'd0, 1'b0, "R3");
    apply(1'b1, 32'h0800_0005, 32'h0000_0010, 32'd0, 32'd0, 1'b0, "R3");
    // R1: index wraps the sum
    apply(1'b0, 32'h0400_0005, 32'hFFFF_FFF0, 32'h0000_0004, 32'h0000_0010, 1'b1, "R1");

    // R11: back-to-back requests each give one response
    @(negedge clk);
    reqValid = 1'b1; reqStore = 1'b0; accDesc = 32'h0400_0001; baseOff = 32'd0; disp = 32'd0; idxEn = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b1, "R11", {95'd0, rspValid}, 96'd1);
    @(negedge clk);
    reqValid = 1'b0;
    check(rspValid == 1'b1, "R11", {95'd0, rspValid}, 96'd1);
    @(negedge clk);
    check(rspValid == 1'b0, "R11", {95'd0, rspValid}, 96'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule